// File: doc/BRIEF.md
# Streaming Shared-Memory Read Prefetch Queue

This block sits beside one processing core and streams consecutive 32-bit longs out of a shared memory that is split into interleaved slices. The memory grants each core one slice per clock and the granted slice steps forward by one every cycle. A start command gives a byte address and a mode bit. From then on the fill engine requests the next sequential long whenever the core's window lines up with that long's slice and buffer space is free. Returned longs are queued, and the core reads bytes, words or longs from the head of the queue in little-endian order.

Every start command is a redirect. It empties the queue, drops read responses that are still on their way for the old stream, and begins refetching from the new address. It does this even when the new address equals the one the consumer would have read next. Bit 31 of the command selects how the core waits. With bit 31 clear, the start blocks: `stall` stays high until the first long has arrived. With bit 31 set, the core carries on at once and has to budget the worst-case fill latency itself.

A three-state controller drives the block. `ST_IDLE` is the state after reset, with no stream. `ST_WAIT` is a blocking start waiting for its first long. `ST_RUN` is a live stream. Its transitions are:
- any state goes to `ST_WAIT` on a start with bit 31 clear;
- any state goes to `ST_RUN` on a start with bit 31 set;
- `ST_WAIT` goes to `ST_RUN` once the queue holds a long;
- otherwise the state is held.

Top module: `hubfifo_stream`

## Requirements
- R1: After a start, the first long requested is the byte address shifted right by two, which is the long containing that byte. The first byte the consumer reads is the byte at the exact start address.
- R2: The window slice resets to CORE_ID and advances by one modulo SLICES every clock. The block requests only when the low log2(SLICES) bits of `mem_addr` equal the current window slice. Successive requests use successive long addresses.
- R3: Queued longs plus live outstanding requests never exceed DEPTH (16). With no consumer reads, exactly DEPTH requests are issued after a start. Each long popped lets exactly one more request be issued.
- R4: `ready` is high exactly when the queue holds at least one long of the current stream. It is low in the cycle after any start. It rises one cycle after the first response is accepted, which is between LAT+1 and SLICES+LAT cycles after the start edge, where LAT is the memory's response latency.
- R5: A start with bit 31 = 0 raises `stall` from the next cycle until the cycle in which `ready` rises. A start with bit 31 = 1 never raises `stall`.
- R6: Every start flushes the queue and refetches, including a start at the very next sequential address. The first request after such a start carries that address again.
- R7: Responses to requests issued before a start are discarded. They never reach the consumer and never raise `ready`.
- R8: `rd_size` encodes 0 = byte, 1 = word, 2 or 3 = long. Data is returned zero-extended and assembled little-endian from the current byte pointer. A read may span two queued longs. A long is popped once all four of its bytes have been read.
- R9: A read that asks for more bytes than the queue holds raises `rd_stall` in that cycle. The read pointer does not advance until enough bytes are present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Start/redirect command strobe |
| start_cmd | input | 32 | Bit 31 selects the mode (0 = blocking, 1 = non-blocking); bits ADDR_W-1:0 hold the byte address |
| stall | output | 1 | Core must hold while a blocking start waits for data |
| ready | output | 1 | At least one long of the current stream is queued |
| rd_valid | input | 1 | Consumer read request |
| rd_size | input | 2 | Read size: 0 = byte, 1 = word, 2 or 3 = long |
| rd_data | output | 32 | Read data, zero-extended |
| rd_stall | output | 1 | Requested bytes are not yet present |
| mem_req | output | 1 | Long read request to the shared memory |
| mem_addr | output | ADDR_W-2 | Long address of the request |
| mem_rsp_valid | input | 1 | Read response strobe, in request order |
| mem_rsp_data | input | 32 | Read response data |

## Verification
The assertions assume three things about the memory side. It answers every request exactly once, it answers in issue order, and it never produces a response without a request. They also assume a consumer read is not counted as taken in a cycle where `rd_stall` is high. The bench's memory model is a fixed-depth pipeline that echoes each `mem_req` after LAT cycles, so the responses are always ordered and one-to-one. The consumer tasks hold `rd_valid` until `rd_stall` falls and then release it right after the edge that takes the read. Redirects are issued while responses are in flight, so that discarding is exercised within those assumptions.

// File: rtl/hubfifo_pkg.sv
package hubfifo_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } run_state_t;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_WORD = 2'd1;
endpackage

// File: rtl/slot_window.sv
module slot_window #(
    parameter int SLICES  = 8,
    parameter int CORE_ID = 0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    output logic [$clog2(SLICES)-1:0]   win
);
    localparam int SL_W = $clog2(SLICES);

    // Granted slice steps by one each clock (SLICES is a power of two).
    always_ff @(posedge clk) begin
        if (!rst_n) win <= SL_W'(CORE_ID);
        else        win <= win + 1'b1;
    end
endmodule

// File: rtl/fill_engine.sv
module fill_engine #(
    parameter int DEPTH  = 16,
    parameter int SLICES = 8,
    parameter int LA_W   = 18
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush,
    input  logic [LA_W-1:0]               flush_la,
    input  logic                          active,
    input  logic [$clog2(SLICES)-1:0]     win,
    input  logic [$clog2(DEPTH+1)-1:0]    buf_count,
    input  logic                          rsp_valid,
    output logic                          mem_req,
    output logic [LA_W-1:0]               mem_addr,
    output logic                          push,
    output logic [$clog2(DEPTH+1)-1:0]    live_cnt
);
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam int SL_W  = $clog2(SLICES);

    logic [LA_W-1:0]  fetch;
    logic [CNT_W-1:0] live;
    logic [CNT_W-1:0] stale;
    logic             room;

    assign room     = ({1'b0, buf_count} + {1'b0, live}) < (CNT_W+1)'(DEPTH);
    assign mem_req  = active && !flush && room && (fetch[SL_W-1:0] == win);
    assign mem_addr = fetch;
    // Responses arrive in order: the oldest 'stale' ones belong to a dead stream.
    assign push     = rsp_valid && !flush && (stale == '0);
    assign live_cnt = live;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch <= '0;
            live  <= '0;
            stale <= '0;
        end else if (flush) begin
            fetch <= flush_la;
            live  <= '0;
            stale <= stale + live - CNT_W'(rsp_valid);
        end else begin
            if (mem_req) fetch <= fetch + 1'b1;
            live <= live + CNT_W'(mem_req) - CNT_W'(push);
            if (rsp_valid && (stale != '0)) stale <= stale - 1'b1;
        end
    end
endmodule

// File: rtl/fifo_buf.sv
module fifo_buf
    import hubfifo_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush,
    input  logic [1:0]                    flush_off,
    input  logic                          push,
    input  logic [31:0]                   push_data,
    input  logic                          rd_valid,
    input  logic [1:0]                    rd_size,
    output logic [$clog2(DEPTH+1)-1:0]    count,
    output logic [31:0]                   rd_data,
    output logic                          rd_stall
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [31:0]      store [DEPTH];
    logic [PTR_W-1:0] wp, rp, rp_nx;
    logic [1:0]       off;
    logic [2:0]       need, span;
    logic [CNT_W+1:0] avail;
    logic             ok, take, pop;
    logic [63:0]      pair, shifted;

    always_comb begin
        unique case (rd_size)
            SZ_BYTE: need = 3'd1;
            SZ_WORD: need = 3'd2;
            default: need = 3'd4;
        endcase
    end

    assign avail    = {count, 2'b00} - (CNT_W+2)'(off);
    assign ok       = (count != '0) && (avail >= (CNT_W+2)'(need));
    assign rd_stall = rd_valid && !ok;
    assign take     = rd_valid && ok && !flush;
    assign span     = {1'b0, off} + need;
    assign pop      = take && span[2];
    assign rp_nx    = rp + 1'b1;
    assign pair     = {store[rp_nx], store[rp]};
    assign shifted  = pair >> {off, 3'b000};

    always_comb begin
        unique case (rd_size)
            SZ_BYTE: rd_data = {24'h0, shifted[7:0]};
            SZ_WORD: rd_data = {16'h0, shifted[15:0]};
            default: rd_data = shifted[31:0];
        endcase
    end

    always_ff @(posedge clk) begin
        if (push) store[wp] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp <= '0; rp <= '0; count <= '0; off <= '0;
        end else if (flush) begin
            wp <= '0; rp <= '0; count <= '0; off <= flush_off;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp_nx;
            count <= count + CNT_W'(push) - CNT_W'(pop);
            if (take) off <= span[1:0];
        end
    end
endmodule

// File: rtl/hubfifo_stream.sv
module hubfifo_stream
    import hubfifo_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int SLICES  = 8,
    parameter int CORE_ID = 0,
    parameter int ADDR_W  = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_valid,
    input  logic [31:0]        start_cmd,
    output logic               stall,
    output logic               ready,
    input  logic               rd_valid,
    input  logic [1:0]         rd_size,
    output logic [31:0]        rd_data,
    output logic               rd_stall,
    output logic               mem_req,
    output logic [ADDR_W-3:0]  mem_addr,
    input  logic               mem_rsp_valid,
    input  logic [31:0]        mem_rsp_data
);
    localparam int LA_W  = ADDR_W - 2;
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam int SL_W  = $clog2(SLICES);

    run_state_t        state, state_nx;
    logic              active, push, non_block;
    logic [ADDR_W-1:0] start_byte;
    logic [SL_W-1:0]   win;
    logic [CNT_W-1:0]  buf_count, live_cnt;

    assign non_block  = start_cmd[31];
    assign start_byte = start_cmd[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (start_valid) begin
            state_nx = non_block ? ST_RUN : ST_WAIT;
        end else begin
            unique case (state)
                ST_IDLE: state_nx = ST_IDLE;
                ST_WAIT: if (buf_count != '0) state_nx = ST_RUN;
                ST_RUN:  state_nx = ST_RUN;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        active = 1'b0;
        stall  = 1'b0;
        ready  = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_WAIT: begin
                active = 1'b1;
                stall  = (buf_count == '0);
                ready  = (buf_count != '0);
            end
            ST_RUN: begin
                active = 1'b1;
                ready  = (buf_count != '0);
            end
            default: ;
        endcase
    end

    slot_window #(.SLICES(SLICES), .CORE_ID(CORE_ID)) u_win (
        .clk(clk), .rst_n(rst_n), .win(win)
    );

    fill_engine #(.DEPTH(DEPTH), .SLICES(SLICES), .LA_W(LA_W)) u_fill (
        .clk(clk), .rst_n(rst_n), .flush(start_valid),
        .flush_la(start_byte[ADDR_W-1:2]), .active(active), .win(win),
        .buf_count(buf_count), .rsp_valid(mem_rsp_valid),
        .mem_req(mem_req), .mem_addr(mem_addr), .push(push), .live_cnt(live_cnt)
    );

    fifo_buf #(.DEPTH(DEPTH)) u_buf (
        .clk(clk), .rst_n(rst_n), .flush(start_valid),
        .flush_off(start_byte[1:0]), .push(push), .push_data(mem_rsp_data),
        .rd_valid(rd_valid), .rd_size(rd_size), .count(buf_count),
        .rd_data(rd_data), .rd_stall(rd_stall)
    );
endmodule

// File: rtl/hubfifo_checker.sv
module hubfifo_checker #(
    parameter int DEPTH = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        start_valid,
    input logic [31:0]                 start_cmd,
    input logic                        stall,
    input logic                        ready,
    input logic                        rd_valid,
    input logic [1:0]                  rd_size,
    input logic                        rd_stall,
    input logic                        mem_req,
    input logic [$clog2(DEPTH+1)-1:0]  buf_count,
    input logic [$clog2(DEPTH+1)-1:0]  live_cnt
);
    localparam int CNT_W = $clog2(DEPTH+1);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, buf_count} + {1'b0, live_cnt}) <= (CNT_W+1)'(DEPTH));

    p_start_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_valid |=> !ready);

    p_block_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_valid && !start_cmd[31]) |=> stall);

    p_nonblock_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_valid && start_cmd[31]) |=> !stall);

    p_stall_not_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !ready);

    p_no_req_on_redirect_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_valid |-> !mem_req);

    p_byte_never_waits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && ready && rd_size == 2'd0) |-> !rd_stall);
endmodule

bind hubfifo_stream hubfifo_checker #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_cmd(start_cmd),
    .stall(stall), .ready(ready), .rd_valid(rd_valid), .rd_size(rd_size),
    .rd_stall(rd_stall), .mem_req(mem_req), .buf_count(buf_count),
    .live_cnt(live_cnt)
);

// File: tb/hubfifo_stream_test.sv
`timescale 1ns/1ps
module hubfifo_stream_test;
    localparam int DEPTH = 16, SLICES = 8, CORE_ID = 3, ADDR_W = 20, LAT = 4;
    localparam int LA_W = ADDR_W - 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_valid = 1'b0;
    logic [31:0] start_cmd = '0;
    logic stall, ready, rd_stall, mem_req;
    logic rd_valid = 1'b0;
    logic [1:0] rd_size = 2'd0;
    logic [31:0] rd_data, mem_rsp_data;
    logic [LA_W-1:0] mem_addr;
    logic mem_rsp_valid;

    int checks = 0, fails = 0, reqs = 0;
    bit seen = 0;
    logic [LA_W-1:0] first_addr;
    logic [2:0] bw;

    always #5 clk = ~clk;

    hubfifo_stream #(.DEPTH(DEPTH), .SLICES(SLICES), .CORE_ID(CORE_ID), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_cmd(start_cmd),
        .stall(stall), .ready(ready), .rd_valid(rd_valid), .rd_size(rd_size),
        .rd_data(rd_data), .rd_stall(rd_stall), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    function automatic logic [31:0] md(input logic [LA_W-1:0] la);
        return {la[15:0] ^ 16'hC3A5, la[15:0] ^ 16'h0F1E};
    endfunction

    // Behavioural memory: fixed-latency, in-order echo of each request.
    logic [LAT-1:0]  pv;
    logic [LA_W-1:0] pa [LAT];
    always @(posedge clk) begin
        if (!rst_n) pv <= '0;
        else begin
            pv <= {pv[LAT-2:0], mem_req};
            pa[0] <= mem_addr;
            for (int i = 1; i < LAT; i++) pa[i] <= pa[i-1];
        end
    end
    assign mem_rsp_valid = pv[LAT-1];
    assign mem_rsp_data  = md(pa[LAT-1]);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Window model and request monitor (R2)
    always @(posedge clk) begin
        if (!rst_n) bw <= 3'(CORE_ID);
        else begin
            if (mem_req) begin
                reqs++;
                if (!seen) begin first_addr = mem_addr; seen = 1; end
                check(mem_addr[2:0] == bw, "R2 slot match", 32'(mem_addr[2:0]), 32'(bw));
            end
            bw <= bw + 1'b1;
        end
    end

    task automatic start(input logic nb, input logic [ADDR_W-1:0] a);
        @(negedge clk);
        start_valid = 1'b1;
        start_cmd = {nb, 11'h0, a};
        reqs = 0; seen = 0;
        @(posedge clk); #1;
        start_valid = 1'b0;
    endtask

    task automatic wait_ready(input string req);
        int n = 0;
        while (!ready && n < 100) begin @(posedge clk); #1; n++; end
        check(n >= LAT + 1 && n <= SLICES + LAT, req, 32'(n), 32'(SLICES + LAT));
    endtask

    task automatic do_read(input logic [1:0] sz, input logic [31:0] exp, input string req);
        int n = 0;
        @(negedge clk);
        rd_valid = 1'b1; rd_size = sz; #1;
        while (rd_stall && n < 100) begin @(negedge clk); #1; n++; end
        check(rd_data == exp, req, rd_data, exp);
        @(posedge clk); #1;
        rd_valid = 1'b0;
    endtask

    task automatic t_reset;
        check(ready == 1'b0, "R4 reset ready", 32'(ready), 0);
        check(stall == 1'b0, "R5 reset stall", 32'(stall), 0);
        check(mem_req == 1'b0, "R2 reset req", 32'(mem_req), 0);
    endtask

    task automatic t_basic;
        logic [31:0] d42, d43, d44;
        d42 = md(18'h42); d43 = md(18'h43); d44 = md(18'h44);
        start(1'b1, 20'h103);
        check(ready == 1'b0, "R4 ready low after start", 32'(ready), 0);
        check(stall == 1'b0, "R5 nonblocking no stall", 32'(stall), 0);
        wait_ready("R4 first-data latency");
        check(first_addr == 18'h40, "R1 first long", 32'(first_addr), 32'h40);
        do_read(2'd0, {24'h0, md(18'h40) >> 24}, "R1 first byte at offset 3");
        do_read(2'd2, md(18'h41), "R8 long after pop");
        do_read(2'd1, {16'h0, d42[15:0]}, "R8 word");
        do_read(2'd3, {d43[15:0], d42[31:16]}, "R8 spanning long");
        do_read(2'd0, {24'h0, d43[23:16]}, "R8 byte");
        do_read(2'd1, {16'h0, d44[7:0], d43[31:24]}, "R8 spanning word");
    endtask

    task automatic t_full;
        start(1'b1, 20'h0);
        repeat (150) @(posedge clk);
        #1;
        check(reqs == DEPTH, "R3 requests capped at depth", 32'(reqs), 32'(DEPTH));
        do_read(2'd2, md(18'h0), "R3 read 0");
        do_read(2'd2, md(18'h1), "R3 read 1");
        do_read(2'd2, md(18'h2), "R3 read 2");
        repeat (40) @(posedge clk);
        #1;
        check(reqs == DEPTH + 3, "R3 refill after pops", 32'(reqs), 32'(DEPTH + 3));
    endtask

    task automatic t_same_addr;
        start(1'b1, 20'h200);
        wait_ready("R4 latency");
        do_read(2'd2, md(18'h80), "R6 before redirect");
        start(1'b1, 20'h204);
        check(ready == 1'b0, "R6 flush on sequential redirect", 32'(ready), 0);
        wait_ready("R6 refill latency");
        check(first_addr == 18'h81, "R6 refetch same address", 32'(first_addr), 32'h81);
        do_read(2'd2, md(18'h81), "R6 data after redirect");
        do_read(2'd2, md(18'h82), "R6 next");
    endtask

    task automatic t_stale;
        int n = 0;
        start(1'b1, 20'h400);
        while (reqs < 2 && n < 50) begin @(posedge clk); #1; n++; end
        start(1'b1, 20'h1000);
        check(ready == 1'b0, "R7 ready low after redirect", 32'(ready), 0);
        wait_ready("R7 latency ignores stale responses");
        do_read(2'd2, md(18'h400), "R7 stale dropped 0");
        do_read(2'd2, md(18'h401), "R7 stale dropped 1");
        do_read(2'd2, md(18'h402), "R7 stale dropped 2");
    endtask

    task automatic t_blocking;
        int n = 0;
        start(1'b0, 20'h800);
        check(stall == 1'b1, "R5 blocking stall", 32'(stall), 1);
        @(negedge clk);
        rd_valid = 1'b1; rd_size = 2'd2; #1;
        check(rd_stall == 1'b1, "R9 empty read stalls", 32'(rd_stall), 1);
        while (stall && n < 100) begin @(posedge clk); #1; n++; end
        check(ready == 1'b1, "R5 stall drops with ready", 32'(ready), 1);
        check(n >= LAT && n <= SLICES + LAT, "R5 stall length", 32'(n), 32'(SLICES + LAT));
        check(rd_stall == 1'b0, "R9 read proceeds", 32'(rd_stall), 0);
        check(rd_data == md(18'h200), "R9 held read data", rd_data, md(18'h200));
        @(posedge clk); #1;
        rd_valid = 1'b0;
        do_read(2'd2, md(18'h201), "R9 no advance while stalled");
    endtask

    initial begin
        #200_000_000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_basic();
        t_full();
        t_same_addr();
        t_stale();
        t_blocking();
        repeat (5) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule